// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block conditions one asynchronous digital input before any edge detection. The raw pin passes through a two-stage synchronizer. It is then sampled at a programmable rate, and a new level is accepted only after a run of consecutive samples agrees on it. A single 4-bit code sets two things together: the sampling period and the number of samples in the run. The codes follow a fixed, irregular table.

Most codes sample on a slow "dead-time" tick. That tick is the internal clock divided by 1, 2 or 4, as set by a 2-bit ratio input, and then divided again by the code's own factor. Codes 1 to 3 are the exception: they sample on every internal clock cycle and ignore the ratio. The outputs are the filtered level and one-cycle pulses marking its rising and falling changes. Software configuration, capture counters and interrupts live elsewhere; here the code and the ratio are plain input ports.

Top module: `inp_deglitch`

## Requirements
- R1: During and directly after reset, `level_o` is 0 and both `rise_o` and `fall_o` are 0.
- R2: Code 0 disables filtering. The input is sampled once per dead-time tick, and a single sample that differs from the level is accepted.
- R3: Codes 1, 2 and 3 sample on every clock cycle, whatever the ratio input is. They need 2, 4 and 8 consecutive differing samples respectively.
- R4: Each remaining code sets a divisor of the dead-time tick and a run length, as follows.
  - Codes 4 and 5: divisor 2, runs of 6 and 8.
  - Codes 6 and 7: divisor 4, runs of 6 and 8.
  - Codes 8 and 9: divisor 8, runs of 6 and 8.
  - Codes 10, 11 and 12: divisor 16, runs of 5, 6 and 8.
  - Codes 13, 14 and 15: divisor 32, runs of 5, 6 and 8.
- R5: The ratio input `dt_ratio` maps 00 to a dead-time divide of 1, 01 to 2 and 10 to 4. The value 11 acts as 00.
- R6: Let P be the sampling period in clock cycles and N the run length. An input pulse lasting N*P cycles or more is accepted, so the level changes. A pulse lasting (N-1)*P cycles or less leaves the level unchanged.
- R7: With a one-cycle sampling period, a change on `din` that is set up before clock edge 1 appears on `level_o` after edge N+2.
- R8: Any sample equal to the current level restarts the run. Glitches separated by one matching sample therefore never add up, however many of them arrive.
- R9: A change of the code or of the ratio restarts the run and the sampling prescaler.
- R10: `rise_o` (`fall_o`) is high for exactly the one cycle in which `level_o` first shows 1 (0). The two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 1 | Raw asynchronous input |
| flt_code | input | 4 | Filter code (sampling divisor and run length) |
| dt_ratio | input | 2 | Dead-time divide select |
| level_o | output | 1 | Filtered level |
| rise_o | output | 1 | One-cycle pulse on a 0-to-1 level change |
| fall_o | output | 1 | One-cycle pulse on a 1-to-0 level change |

## Verification
The hardest situation to reach from the ports is a configuration change that lands in the middle of a partly counted run. Seen from the ports, the only effect is a later acceptance time.

The stimulus holds `din` high on the 8-sample code. After three matching samples it switches the code to a 4-sample setting for one cycle. Without the restart, that cycle would complete the run at once. The stimulus then switches the code back and checks that the level is still low well past the point an unrestarted run would have finished. A table of pulse widths placed exactly at N*P and (N-1)*P probes every code's divisor and run length from both sides.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;

  localparam int CODE_W  = 4;
  localparam int RATIO_W = 2;
  localparam int RUN_W   = 4;
  localparam int PRE_W   = 8;

  // run length needed to accept a new level
  function automatic logic [RUN_W-1:0] run_len(input logic [CODE_W-1:0] code);
    logic [RUN_W-1:0] r;
    case (code)
      4'd0:  r = 4'd1;
      4'd1:  r = 4'd2;
      4'd2:  r = 4'd4;
      4'd3:  r = 4'd8;
      4'd10, 4'd13: r = 4'd5;
      4'd4, 4'd6, 4'd8, 4'd11, 4'd14: r = 4'd6;
      default: r = 4'd8;
    endcase
    return r;
  endfunction

  // dead-time divide as a power of two exponent
  function automatic int unsigned ratio_exp(input logic [RATIO_W-1:0] dtr);
    int unsigned e;
    case (dtr)
      2'b01:   e = 1;
      2'b10:   e = 2;
      default: e = 0;
    endcase
    return e;
  endfunction

  // code divisor of the dead-time tick as a power of two exponent
  function automatic int unsigned code_exp(input logic [CODE_W-1:0] code);
    int unsigned e;
    if (code == 4'd0)       e = 0;
    else if (code <= 4'd5)  e = 1;
    else if (code <= 4'd7)  e = 2;
    else if (code <= 4'd9)  e = 3;
    else if (code <= 4'd12) e = 4;
    else                    e = 5;
    return e;
  endfunction

  function automatic logic uses_fast_clk(input logic [CODE_W-1:0] code);
    return (code >= 4'd1) && (code <= 4'd3);
  endfunction

  // sampling period in clock cycles, minus one
  function automatic logic [PRE_W-1:0] period_m1(input logic [CODE_W-1:0] code,
                                                 input logic [RATIO_W-1:0] dtr);
    int unsigned p;
    if (uses_fast_clk(code)) p = 1;
    else p = 1 << (ratio_exp(dtr) + code_exp(code));
    return PRE_W'(p - 1);
  endfunction

endpackage

// File: rtl/deglitch_sync.sv
module deglitch_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/deglitch_strobe.sv
module deglitch_strobe #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] per_m1,
  output logic             strobe
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pre_q <= '0;
    else if (restart || pre_q >= per_m1) pre_q <= '0;
    else                                 pre_q <= pre_q + 1'b1;
  end

  assign strobe = (pre_q == per_m1);

  // R4
  pre_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (pre_q <= per_m1));

  // R9
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0));
endmodule

// File: rtl/deglitch_event.sv
module deglitch_event #(
  parameter int RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             sample,
  input  logic             clear,
  input  logic [RUN_W-1:0] need,
  output logic             level_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             accept
);
  logic [RUN_W-1:0] run_q;
  logic             level_q, rise_q, fall_q;
  logic             differs;
  logic [RUN_W:0]   run_next;

  assign differs  = (sample != level_q);
  assign run_next = {1'b0, run_q} + 1'b1;
  assign accept   = strobe && !clear && differs && (run_next >= {1'b0, need});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      level_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      rise_q <= accept && sample;
      fall_q <= accept && !sample;
      if (clear)             run_q <= '0;
      else if (strobe) begin
        if (!differs)        run_q <= '0;
        else if (accept) begin
          run_q   <= '0;
          level_q <= sample;
        end else             run_q <= run_next[RUN_W-1:0];
      end
    end
  end

  assign level_o = level_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;

  // R8
  run_below_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> (run_q < need));

  // R8
  match_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !clear && !differs) |=> (run_q == '0));

  // R9
  cfg_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (run_q == '0));

  // R6
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(level_q));

  // R10
  rise_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (level_q && !$past(level_q)));

  // R10
  fall_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> (!level_q && $past(level_q)));

  // R10
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_q && fall_q));
endmodule

// File: rtl/inp_deglitch.sv
module inp_deglitch
  import deglitch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               din,
  input  logic [CODE_W-1:0]  flt_code,
  input  logic [RATIO_W-1:0] dt_ratio,
  output logic               level_o,
  output logic               rise_o,
  output logic               fall_o
);
  localparam int CFG_W = CODE_W + RATIO_W;

  logic [CFG_W-1:0] cfg_q;
  logic             cfg_changed;
  logic             sample_w;
  logic             strobe_w;
  logic             accept_w;
  logic [PRE_W-1:0] per_m1_w;
  logic [RUN_W-1:0] need_w;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= {flt_code, dt_ratio};

  assign cfg_changed = ({flt_code, dt_ratio} != cfg_q);
  assign per_m1_w    = period_m1(flt_code, dt_ratio);
  assign need_w      = run_len(flt_code);

  deglitch_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(din), .sync_o(sample_w)
  );

  deglitch_strobe #(.PRE_W(PRE_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .restart(cfg_changed),
    .per_m1(per_m1_w), .strobe(strobe_w)
  );

  deglitch_event #(.RUN_W(RUN_W)) u_event (
    .clk(clk), .rst_n(rst_n), .strobe(strobe_w), .sample(sample_w),
    .clear(cfg_changed), .need(need_w),
    .level_o(level_o), .rise_o(rise_o), .fall_o(fall_o), .accept(accept_w)
  );

  // R3
  fast_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uses_fast_clk(flt_code) && !cfg_changed) |-> strobe_w);

  // R2
  nofilter_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_code == 4'd0 && strobe_w && !cfg_changed && sample_w != level_o) |-> accept_w);
endmodule

// File: tb/inp_deglitch_bench.sv
module inp_deglitch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       din = 1'b0;
  logic [3:0] flt_code = 4'd0;
  logic [1:0] dt_ratio = 2'd0;
  logic       level_o, rise_o, fall_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  inp_deglitch u_inp_deglitch (
    .clk(clk), .rst_n(rst_n), .din(din), .flt_code(flt_code),
    .dt_ratio(dt_ratio), .level_o(level_o), .rise_o(rise_o), .fall_o(fall_o)
  );

  // code, ratio, pulse width in cycles, 1 = accepted
  localparam int NV = 31;
  localparam int VEC [NV][4] = '{
    '{0, 0, 1, 1},     '{0, 2, 4, 1},     '{0, 3, 1, 1},
    '{1, 1, 2, 1},     '{1, 1, 1, 0},     '{2, 2, 4, 1},
    '{2, 2, 3, 0},     '{3, 0, 8, 1},     '{3, 0, 7, 0},
    '{4, 0, 12, 1},    '{4, 0, 10, 0},    '{5, 1, 32, 1},
    '{5, 1, 28, 0},    '{7, 0, 32, 1},    '{7, 0, 28, 0},
    '{6, 0, 24, 1},    '{6, 0, 20, 0},    '{8, 1, 96, 1},
    '{8, 1, 80, 0},    '{9, 1, 128, 1},   '{9, 1, 112, 0},
    '{10, 0, 80, 1},   '{10, 0, 64, 0},   '{11, 0, 96, 1},
    '{11, 0, 80, 0},   '{12, 2, 512, 1},  '{12, 2, 448, 0},
    '{13, 0, 160, 1},  '{13, 0, 128, 0},  '{14, 3, 192, 1},
    '{14, 3, 160, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int code, input int dtr);
    if (code == 0)       return "R2/R6";
    else if (code <= 3)  return "R3/R6";
    else if (dtr == 3)   return "R5/R6";
    else                 return "R4/R6";
  endfunction

  task automatic settle(input int code, input int dtr, input int cycles);
    @(negedge clk);
    flt_code = 4'(code);
    dt_ratio = 2'(dtr);
    din = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic run_vec(input int code, input int dtr, input int w, input int pass);
    int rises = 0;
    int falls = 0;
    settle(code, dtr, 10);
    din = 1'b1;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      rises += int'(rise_o);
      falls += int'(fall_o);
    end
    din = 1'b0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      rises += int'(rise_o);
      falls += int'(fall_o);
    end
    chk({tag_of(code, dtr), " rise count"}, rises, pass);
    chk({tag_of(code, dtr), " fall count"}, falls, pass);
    chk({tag_of(code, dtr), " final level"}, int'(level_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 level in reset", int'(level_o), 0);
    chk("R1 rise in reset", int'(rise_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 level after reset", int'(level_o), 0);
    chk("R1 fall after reset", int'(fall_o), 0);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

    // R7 exact latency, code 1 (N=2): level after edge 4
    settle(1, 2, 12);
    din = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 level before edge 4", int'(level_o), 0);
    @(negedge clk);
    chk("R7 level after edge 4", int'(level_o), 1);
    chk("R10 rise with level", int'(rise_o), 1);
    @(negedge clk);
    chk("R10 rise one cycle", int'(rise_o), 0);
    settle(1, 2, 12);

    // R7 code 0 ratio 00 (N=1): level after edge 3
    settle(0, 0, 12);
    din = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 no-filter before edge 3", int'(level_o), 0);
    @(negedge clk);
    chk("R7 no-filter after edge 3", int'(level_o), 1);
    settle(0, 0, 12);

    // R8 repeated 3-sample glitches on code 2 (N=4) never accumulate
    begin
      int rises = 0;
      settle(2, 0, 12);
      for (int k = 0; k < 5; k++) begin
        din = 1'b1;
        repeat (3) begin @(negedge clk); rises += int'(rise_o); end
        din = 1'b0;
        @(negedge clk); rises += int'(rise_o);
      end
      repeat (10) begin @(negedge clk); rises += int'(rise_o); end
      chk("R8 glitch train rises", rises, 0);
      chk("R8 glitch train level", int'(level_o), 0);
    end

    // R9 config change mid-run restarts the count
    settle(3, 0, 12);
    din = 1'b1;
    repeat (5) @(negedge clk);
    flt_code = 4'd2;
    @(negedge clk);
    flt_code = 4'd3;
    repeat (6) @(negedge clk);
    chk("R9 level after edge 12", int'(level_o), 0);
    repeat (4) @(negedge clk);
    chk("R9 level after edge 16", int'(level_o), 1);
    settle(3, 0, 20);
    chk("R9 level back low", int'(level_o), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule